// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block computes a 16-bit check value over a run of 32-bit words that arrive in big-endian order. Each word takes eight clock cycles, because the block processes one 4-bit nibble per cycle. Each cycle it folds the top nibble of the accumulator into the incoming nibble. The feedback is a three-term XOR: the 4-bit sum is added back at shifts of 12, 5 and 0. This is not a bitwise or bytewise LFSR.

A computation begins with a one-cycle `start` pulse that carries the number of words. Words are then handed over one at a time through a valid/ready handshake. When the last nibble of the last word has been folded in, a one-cycle `done` pulse marks the result on `crc_out`.

The result is intended for the header word of a bus topology or speed map. That header holds the covered-word count in its upper half and the CRC in its lower half, and the block builds it on `header_out`. A topology map covers the self-ID count plus two words. A speed map covers 0x3F1 words.

Top module: `crc16n_engine`

## Requirements
- R1: An accepted `start` clears the accumulator to zero, so `crc_out` reads 0 in the cycle after the start edge.
- R2: Each word is consumed most-significant nibble first, from bits 31:28 down to bits 3:0, in eight steps per word.
- R3: Each step forms s = acc[15:12] XOR nibble. The next accumulator is ((acc << 4) XOR (s << 12) XOR (s << 5) XOR s), truncated to 16 bits.
- R4: A start with a word count of zero raises `done` in the cycle after the start edge, with `crc_out` equal to 0.
- R5: `in_ready` is high while a computation waits for its next word. It is low for the seven cycles after a word is accepted. A word offered immediately afterwards is accepted eight cycles after the previous one.
- R6: `done` rises in the eighth cycle after the last word is accepted, counting the cycle right after acceptance as the first. It lasts exactly one cycle.
- R7: `crc_out` keeps its final value until the next accepted start.
- R8: `header_out` carries the word count given at start in bits 31:16 and the current `crc_out` in bits 15:0.
- R9: A `start` that arrives while a computation is running has no effect. `in_ready` is low when no computation is running, so offered words are not accepted.
- R10: Reset is asynchronous and active low. After reset, `in_ready` and `done` are low and `crc_out` and `header_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (ignored while busy) |
| word_count | input | CNT_W | Number of words to cover, sampled with start |
| in_valid | input | 1 | A word is offered on in_word |
| in_ready | output | 1 | The engine takes a word this cycle if in_valid is high |
| in_word | input | 32 | Big-endian data word |
| crc_out | output | 16 | Running and final check value |
| done | output | 1 | One-cycle pulse: crc_out is final |
| header_out | output | 32 | Map header: word count in bits 31:16, CRC in bits 15:0 |

## Verification
The bench samples each result a fixed number of cycles after its stimulus.
- A zero-count start is checked on the first falling edge after the start edge.
- After each word is accepted, `in_ready` and `done` are checked low on falling edges one through seven. On falling edge eight, either `done` together with the final CRC and header is expected, or `in_ready` high for the next word.
- The falling edge after that must show `done` low again.
- On the following falling edges, `crc_out` must hold its value.

All inputs are driven on falling edges, so every sample falls half a period away from the edge that produced it. Expected CRCs are computed in the bench with the step equation. The stimulus covers:
- single words that sweep every nibble value through every position;
- multi-word runs with and without idle gaps;
- a topology-style run and a full speed-map-length run.

// File: rtl/crc16n_pkg.sv
package crc16n_pkg;

  localparam int WORD_W        = 32;
  localparam int NIB_W         = 4;
  localparam int CRC_W         = 16;
  localparam int NIBS_PER_WORD = WORD_W / NIB_W;
  localparam int NIB_CNT_W     = $clog2(NIBS_PER_WORD);

  // One nibble of the three-term feedback update.
  function automatic logic [CRC_W-1:0] crc_nib_step(input logic [CRC_W-1:0] acc,
                                                    input logic [NIB_W-1:0] nib);
    logic [NIB_W-1:0] s;
    logic [CRC_W-1:0] sw;
    s  = acc[CRC_W-1 -: NIB_W] ^ nib;
    sw = {{(CRC_W-NIB_W){1'b0}}, s};
    return (acc << NIB_W) ^ (sw << 12) ^ (sw << 5) ^ sw;
  endfunction

endpackage

// File: rtl/crc16n_datapath.sv
module crc16n_datapath
  import crc16n_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] in_word,
  output logic [CRC_W-1:0]  acc_q
);

  localparam int REST_W = WORD_W - NIB_W;

  logic [REST_W-1:0] rest_q, rest_d;
  logic [CRC_W-1:0]  acc_d;
  logic [NIB_W-1:0]  nib;
  logic              step_en;

  // The first nibble is taken straight from the input word on acceptance.
  always_comb begin
    step_en = load | shift_en;
    nib     = load ? in_word[WORD_W-1 -: NIB_W] : rest_q[REST_W-1 -: NIB_W];
    rest_d  = rest_q;
    acc_d   = acc_q;
    if (load)
      rest_d = in_word[REST_W-1:0];
    else if (shift_en)
      rest_d = {rest_q[REST_W-NIB_W-1:0], {NIB_W{1'b0}}};
    if (clear)
      acc_d = '0;
    else if (step_en)
      acc_d = crc_nib_step(acc_q, nib);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (clear | step_en)
      acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rest_q <= '0;
    else if (step_en)
      rest_q <= rest_d;
  end

  assert_acc_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0));

  assert_acc_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && !shift_en) |=> $stable(acc_q));

endmodule

// File: rtl/crc16n_ctrl.sv
module crc16n_ctrl
  import crc16n_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] word_count,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             clear,
  output logic             load,
  output logic             shift_en,
  output logic             done,
  output logic             busy,
  output logic [CNT_W-1:0] len_q
);

  logic                 busy_q, busy_d;
  logic                 active_q, active_d;
  logic                 last_q, last_d;
  logic                 done_q, done_d;
  logic [NIB_CNT_W-1:0] nib_q, nib_d;
  logic [CNT_W-1:0]     left_q, left_d;
  logic                 start_ok;

  always_comb begin
    start_ok = start & ~busy_q;
    in_ready = busy_q & ~active_q;
    load     = in_valid & in_ready;
    shift_en = active_q;
    clear    = start_ok;

    busy_d   = busy_q;
    active_d = active_q;
    last_d   = last_q;
    nib_d    = nib_q;
    left_d   = left_q;
    done_d   = 1'b0;

    if (start_ok) begin
      left_d = word_count;
      if (word_count == '0)
        done_d = 1'b1;
      else
        busy_d = 1'b1;
    end
    if (load) begin
      active_d = 1'b1;
      nib_d    = NIB_CNT_W'(NIBS_PER_WORD - 1);
      left_d   = left_q - CNT_W'(1);
      last_d   = (left_q == CNT_W'(1));
    end
    if (active_q) begin
      nib_d = nib_q - NIB_CNT_W'(1);
      if (nib_q == NIB_CNT_W'(1)) begin
        active_d = 1'b0;
        if (last_q) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      last_q   <= 1'b0;
      nib_q    <= '0;
      left_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      active_q <= active_d;
      last_q   <= last_d;
      nib_q    <= nib_d;
      left_q   <= left_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      len_q <= '0;
    else if (start_ok)
      len_q <= word_count;
  end

  assign done = done_q;
  assign busy = busy_q;

  assert_zero_count_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && word_count == '0) |=> done);

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(len_q));

  assert_nib_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (nib_q != '0));

endmodule

// File: rtl/crc16n_hdr.sv
module crc16n_hdr
  import crc16n_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit HDR_EN = 1'b1
) (
  input  logic [CNT_W-1:0]  len,
  input  logic [CRC_W-1:0]  crc,
  output logic [WORD_W-1:0] header
);

  localparam int LEN_W = WORD_W - CRC_W;

  generate
    if (HDR_EN) begin : g_hdr
      assign header = {LEN_W'(len), crc};
    end else begin : g_no_hdr
      logic unused_ok;
      assign unused_ok = ^{len, crc};
      assign header    = '0;
    end
  endgenerate

endmodule

// File: rtl/crc16n_engine.sv
module crc16n_engine
  import crc16n_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit HDR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic [CRC_W-1:0]  crc_out,
  output logic              done,
  output logic [WORD_W-1:0] header_out
);

  logic             clear, load, shift_en, busy;
  logic [CNT_W-1:0] len_q;

  crc16n_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_count (word_count),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .clear      (clear),
    .load       (load),
    .shift_en   (shift_en),
    .done       (done),
    .busy       (busy),
    .len_q      (len_q)
  );

  crc16n_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load     (load),
    .shift_en (shift_en),
    .in_word  (in_word),
    .acc_q    (crc_out)
  );

  crc16n_hdr #(.CNT_W(CNT_W), .HDR_EN(HDR_EN)) u_hdr (
    .len    (len_q),
    .crc    (crc_out),
    .header (header_out)
  );

  assert_crc_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(crc_out));

  assert_idle_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

endmodule

// File: tb/crc16n_engine_tb.sv
`timescale 1ns/1ps
module crc16n_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] word_count;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic [15:0] crc_out;
  logic        done;
  logic [31:0] header_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [31:0] mem [0:1023];

  always #10 clk = ~clk;

  crc16n_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .crc_out(crc_out), .done(done), .header_out(header_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected CRC from the step equation (R2, R3).
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] a = 16'h0;
    for (int i = 0; i < n; i++) begin
      for (int p = 7; p >= 0; p--) begin
        logic [3:0]  s;
        logic [15:0] sw;
        s  = a[15:12] ^ mem[i][p*4 +: 4];
        sw = {12'h0, s};
        a  = (a << 4) ^ (sw << 12) ^ (sw << 5) ^ sw;
      end
    end
    return a;
  endfunction

  task automatic run(input int n, input int gap, input bit poke);
    logic [15:0] exp;
    exp = ref_crc(n);
    @(negedge clk); start = 1'b1; word_count = 16'(n);
    @(negedge clk); start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R4 done", {31'h0, done}, 32'h1);
      chk(crc_out == 16'h0, "R4 crc", {16'h0, crc_out}, 32'h0);
      chk(header_out == 32'h0, "R8 hdr", header_out, 32'h0);
      @(negedge clk);
      chk(done == 1'b0, "R6 pulse", {31'h0, done}, 32'h0);
      return;
    end
    chk(crc_out == 16'h0, "R1 clear", {16'h0, crc_out}, 32'h0);
    chk(in_ready == 1'b1, "R5 ready", {31'h0, in_ready}, 32'h1);
    for (int i = 0; i < n; i++) begin
      if (gap > 0) repeat (gap) @(negedge clk);
      in_valid = 1'b1; in_word = mem[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk); in_valid = 1'b0; in_word = 32'hDEAD_BEEF;
      for (int k = 1; k <= 7; k++) begin
        if (k > 1) @(negedge clk);
        chk(!in_ready, "R5 busy", {31'h0, in_ready}, 32'h0);
        chk(!done, "R6 early", {31'h0, done}, 32'h0);
        if (poke && i == 0 && k == 2) begin start = 1'b1; word_count = 16'h0; end
        if (k == 3) start = 1'b0;
      end
      @(negedge clk);
      if (i == n - 1) begin
        chk(done == 1'b1, "R6 done", {31'h0, done}, 32'h1);
        chk(crc_out == exp, poke ? "R9 crc" : "R3 crc", {16'h0, crc_out}, {16'h0, exp});
        chk(header_out == {16'(n), exp}, "R8 hdr", header_out, {16'(n), exp});
        @(negedge clk);
        chk(done == 1'b0, "R6 pulse", {31'h0, done}, 32'h0);
        repeat (3) @(negedge clk);
        chk(crc_out == exp, "R7 hold", {16'h0, crc_out}, {16'h0, exp});
      end else begin
        chk(in_ready == 1'b1, "R5 next", {31'h0, in_ready}, 32'h1);
      end
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; word_count = '0; in_valid = 1'b0; in_word = '0;
    for (int i = 0; i < 1024; i++)
      mem[i] = (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7) ^ 32'h5A5A_0F0F;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R10 ready", {31'h0, in_ready}, 32'h0);
    chk(done == 1'b0, "R10 done", {31'h0, done}, 32'h0);
    chk(crc_out == 16'h0, "R10 crc", {16'h0, crc_out}, 32'h0);
    chk(header_out == 32'h0, "R10 hdr", header_out, 32'h0);
    rst_n = 1'b1;

    // R9: words offered with no computation running are not taken.
    @(negedge clk); in_valid = 1'b1; in_word = 32'hFFFF_FFFF;
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 idle", {31'h0, in_ready}, 32'h0);
      chk(crc_out == 16'h0, "R9 idle crc", {16'h0, crc_out}, 32'h0);
    end
    in_valid = 1'b0;

    run(0, 0, 1'b0);                                   // R4

    // R2/R3: every nibble value in every position of a single word.
    for (int p = 0; p < 8; p++)
      for (int v = 0; v < 16; v++) begin
        mem[0] = 32'(v) << (4 * p);
        run(1, 0, 1'b0);
      end
    for (int i = 0; i < 1024; i++)
      mem[i] = (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7) ^ 32'h5A5A_0F0F;

    for (int n = 1; n <= 6; n++) run(n, n % 3, 1'b0);  // gaps and back-to-back
    run(3, 0, 1'b1);                                   // R9 start while busy
    run(0, 0, 1'b0);                                   // R4 after a run
    run(5, 0, 1'b0);                                   // topology-style: 3 self-IDs + 2
    run(16'h3F1, 0, 1'b0);                             // speed-map length
    finish_up();
  end

endmodule